// File: doc/BRIEF.md
# PCI Bus Cycle Status Generator

This block watches a PCI bus without driving it. On every rising clock edge it takes a registered copy of all bus signals except the clock. It works out per-clock status for a capture system from that copy alone. Three active-low pulses mark three events:

- the final data phase of a transaction,
- a clock whose local parity disagrees with the PAR value the bus carried for it,
- a master abort, when no target claimed the cycle in time.

A separate active-high strobe marks the clock on which a new transaction's FRAME# first appears.

The registered bus copy is also presented on a wide output vector so that the capture system can record it. That vector is driven only in state mode. In timing mode it is released to high impedance and the capture system samples the raw bus itself.

Two inputs control the block. A parity-check enable gates the parity pulse. A mode select chooses between state mode and timing mode.

Top module: `pci_cycle_status`

## Requirements
- R1: On each rising edge all non-clock bus inputs are registered; in state mode `latchOut` presents that copy with bit layout [44:13] AD, [12:9] C/BE#, [8] PAR, [7] FRAME#, [6] IRDY#, [5] TRDY#, [4] STOP#, [3] DEVSEL#, [2] IDSEL, [1] PERR#, [0] SERR#.
- R2: When `stateMode` is 0 (timing mode), `latchOut` is high impedance and does not present the registered copy.
- R3: `addrValid` goes high for exactly one clock, right after the edge that samples FRAME# low when the previous sample had both FRAME# and IRDY# deasserted. It stays low on the clocks that follow while FRAME# is held.
- R4: `endXferN` is low for one clock, one clock after the edge that sampled the last data phase of a transaction. The last data phase is FRAME# high, IRDY# low, and TRDY# or STOP# low. Transfers ended either by TRDY# or by STOP# qualify.
- R5: Local parity is even parity over AD and C/BE#, compared with the PAR sampled on the next edge. `parErrN` is low for one clock, two clocks after a mismatching phase's edge. Only the address phase and clocks with both IRDY# and TRDY# low are checked.
- R6: `parErrN` never goes low while `parityCheckEn` is 0.
- R7: On a single-data-phase transfer (FRAME# high at the first clock after the address phase), `mAbortN` pulses low for one clock when DEVSEL# was not sampled low on any of the first five clocks. The address clock counts as clock 1, and the pulse comes one clock after the fifth clock's edge.
- R8: On a multi-beat transfer (FRAME# still low at the first clock after the address phase), no abort fires at clock five. `mAbortN` pulses low one clock after the sixth clock's edge when DEVSEL# was never sampled low.
- R9: DEVSEL# sampled low on any clock up to and including the timeout clock suppresses the master-abort pulse for that transaction.
- R10: All status outputs are registered. A synchronous active-low `rstN` deasserts every flag (`endXferN`, `parErrN`, `mAbortN` high, `addrValid` low) and clears transaction tracking, so a transaction in progress before reset produces no flag afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI bus clock |
| rstN | input | 1 | Synchronous reset, active low |
| stateMode | input | 1 | 1 = state mode (drive `latchOut`), 0 = timing mode |
| parityCheckEn | input | 1 | Enables the parity mismatch flag |
| adIn | input | 32 | AD bus |
| cbeNIn | input | 4 | C/BE# lines |
| parIn | input | 1 | PAR |
| frameNIn | input | 1 | FRAME# |
| irdyNIn | input | 1 | IRDY# |
| trdyNIn | input | 1 | TRDY# |
| stopNIn | input | 1 | STOP# |
| devselNIn | input | 1 | DEVSEL# |
| idselIn | input | 1 | IDSEL |
| perrNIn | input | 1 | PERR# |
| serrNIn | input | 1 | SERR# |
| latchOut | output | 45 | Registered bus copy, high impedance in timing mode |
| addrValid | output | 1 | One-clock strobe at the start of a transaction |
| endXferN | output | 1 | Last-data-phase flag, active low |
| parErrN | output | 1 | Parity mismatch flag, active low |
| mAbortN | output | 1 | Master-abort flag, active low |

## Verification
The bench targets the master-abort boundary between single and multi-beat transfers. A design that used one timeout for both would pulse at clock five of a burst, or wait until clock six on a single transfer. DEVSEL# arriving exactly on the sixth clock of a burst must suppress the abort; an off-by-one window would flag it anyway. The bench corrupts PAR on address, data and wait-state clocks and checks the two-clock flag latency. A design that checked wait states, or lined PAR up with the wrong phase, would flag the wrong clock. A reset in the middle of an unclaimed burst must leave no tracking behind; a design that kept its counter would raise a late abort once IRDY# stays low after reset.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  localparam int AD_W  = 32;
  localparam int CBE_W = 4;

  // Registered image of the bus; field order defines the latchOut bit layout.
  typedef struct packed {
    logic [AD_W-1:0]  ad;
    logic [CBE_W-1:0] cbeN;
    logic             par;
    logic             frameN;
    logic             irdyN;
    logic             trdyN;
    logic             stopN;
    logic             devselN;
    logic             idsel;
    logic             perrN;
    logic             serrN;
  } busT;

  localparam int BUS_W = $bits(busT);

  localparam busT BUS_IDLE = '{
    ad: '0, cbeN: '1, par: 1'b0,
    frameN: 1'b1, irdyN: 1'b1, trdyN: 1'b1, stopN: 1'b1, devselN: 1'b1,
    idsel: 1'b0, perrN: 1'b1, serrN: 1'b1
  };

  // Handshake lines the control path needs from the registered copy.
  typedef struct packed {
    logic frameN;
    logic irdyN;
    logic trdyN;
    logic stopN;
    logic devselN;
  } ctlViewT;

  // Strobes from control to datapath, all for the phase currently registered.
  typedef struct packed {
    logic parChk;   // phase carries parity to be checked next clock
    logic endXfer;  // phase is the last data phase
    logic abort;    // phase is the master-abort timeout clock
  } strobeT;

endpackage

// File: rtl/pcs_parity.sv
module pcs_parity #(
  parameter int WIDTH = 36
) (
  input  logic [WIDTH-1:0] bits,
  output logic             odd
);

  logic [WIDTH-1:0] chain;

  assign chain[0] = bits[0];

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_xor
      assign chain[i] = chain[i-1] ^ bits[i];
    end
  endgenerate

  assign odd = chain[WIDTH-1];

endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               stateMode,
  input  logic               parityCheckEn,
  input  busT                busIn,
  input  strobeT             strobe,
  output ctlViewT            ctlView,
  output logic               prevIdle,
  output logic [BUS_W-1:0]   latchOut,
  output logic               addrValid,
  output logic               endXferN,
  output logic               parErrN,
  output logic               mAbortN
);

  localparam int PAR_W = AD_W + CBE_W;

  busT  busQ;
  logic parPrev;
  logic chkPending;
  logic parNow;
  logic startSeen;
  logic mismatch;

  pcs_parity #(.WIDTH(PAR_W)) u_par (
    .bits ({busQ.ad, busQ.cbeN}),
    .odd  (parNow)
  );

  assign startSeen = !busIn.frameN && busQ.frameN && busQ.irdyN;
  assign mismatch  = chkPending && parityCheckEn && (parPrev != busQ.par);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busQ       <= BUS_IDLE;
      parPrev    <= 1'b0;
      chkPending <= 1'b0;
      prevIdle   <= 1'b1;
      addrValid  <= 1'b0;
      endXferN   <= 1'b1;
      parErrN    <= 1'b1;
      mAbortN    <= 1'b1;
    end else begin
      busQ       <= busIn;
      parPrev    <= parNow;
      chkPending <= strobe.parChk;
      prevIdle   <= busQ.frameN && busQ.irdyN;
      addrValid  <= startSeen;
      endXferN   <= !strobe.endXfer;
      parErrN    <= !mismatch;
      mAbortN    <= !strobe.abort;
    end
  end

  assign ctlView = '{frameN: busQ.frameN, irdyN: busQ.irdyN, trdyN: busQ.trdyN,
                     stopN: busQ.stopN, devselN: busQ.devselN};

  assign latchOut = stateMode ? busQ : {BUS_W{1'bz}};

endmodule

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
#(
  parameter int ABORT_SINGLE = 5,
  parameter int ABORT_BURST  = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  ctlViewT ctlView,
  input  logic    prevIdle,
  output strobeT  strobe
);

  localparam int MAX_LIM = (ABORT_BURST > ABORT_SINGLE) ? ABORT_BURST : ABORT_SINGLE;
  localparam int CNT_W   = $clog2(MAX_LIM + 2);
  localparam logic [CNT_W-1:0] LIM_SINGLE = CNT_W'(ABORT_SINGLE);
  localparam logic [CNT_W-1:0] LIM_BURST  = CNT_W'(ABORT_BURST);
  localparam logic [CNT_W-1:0] CNT_SAT    = CNT_W'(MAX_LIM);
  localparam logic [CNT_W-1:0] CNT_FIRST  = CNT_W'(1);

  logic             active;
  logic [CNT_W-1:0] clkCnt;
  logic             burst;
  logic             devSeen;

  logic             addrPhase;
  logic [CNT_W-1:0] cntNow;
  logic             burstNow;
  logic             seenNow;
  logic [CNT_W-1:0] limit;
  logic             lastData;
  logic             dataXfer;
  logic             busIdle;
  logic             abortNow;
  logic             endNow;

  always_comb begin
    addrPhase = !active && !ctlView.frameN && prevIdle;
    cntNow    = clkCnt + CNT_W'(1);
    burstNow  = (clkCnt == CNT_FIRST) ? !ctlView.frameN : burst;
    seenNow   = devSeen || !ctlView.devselN;
    limit     = burstNow ? LIM_BURST : LIM_SINGLE;
    lastData  = ctlView.frameN && !ctlView.irdyN && (!ctlView.trdyN || !ctlView.stopN);
    dataXfer  = !ctlView.irdyN && !ctlView.trdyN;
    busIdle   = ctlView.frameN && ctlView.irdyN;
    abortNow  = active && !seenNow && (cntNow == limit);
    endNow    = active && lastData;
  end

  assign strobe = '{parChk:  addrPhase || (active && dataXfer),
                    endXfer: endNow,
                    abort:   abortNow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      clkCnt  <= '0;
      burst   <= 1'b0;
      devSeen <= 1'b0;
    end else if (addrPhase) begin
      active  <= 1'b1;
      clkCnt  <= CNT_FIRST;
      burst   <= 1'b0;
      devSeen <= !ctlView.devselN;
    end else if (active) begin
      if (endNow || abortNow || busIdle) begin
        active <= 1'b0;
      end else begin
        if (clkCnt != CNT_SAT) clkCnt <= cntNow;
        burst   <= burstNow;
        devSeen <= seenNow;
      end
    end
  end

endmodule

// File: rtl/pci_cycle_status.sv
module pci_cycle_status
  import pcs_pkg::*;
#(
  parameter int ABORT_SINGLE = 5,
  parameter int ABORT_BURST  = 6
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       stateMode,
  input  logic                       parityCheckEn,
  input  logic [pcs_pkg::AD_W-1:0]   adIn,
  input  logic [pcs_pkg::CBE_W-1:0]  cbeNIn,
  input  logic                       parIn,
  input  logic                       frameNIn,
  input  logic                       irdyNIn,
  input  logic                       trdyNIn,
  input  logic                       stopNIn,
  input  logic                       devselNIn,
  input  logic                       idselIn,
  input  logic                       perrNIn,
  input  logic                       serrNIn,
  output logic [pcs_pkg::BUS_W-1:0]  latchOut,
  output logic                       addrValid,
  output logic                       endXferN,
  output logic                       parErrN,
  output logic                       mAbortN
);

  busT     busIn;
  ctlViewT ctlView;
  strobeT  strobe;
  logic    prevIdle;

  assign busIn = '{ad: adIn, cbeN: cbeNIn, par: parIn,
                   frameN: frameNIn, irdyN: irdyNIn, trdyN: trdyNIn,
                   stopN: stopNIn, devselN: devselNIn,
                   idsel: idselIn, perrN: perrNIn, serrN: serrNIn};

  pcs_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stateMode     (stateMode),
    .parityCheckEn (parityCheckEn),
    .busIn         (busIn),
    .strobe        (strobe),
    .ctlView       (ctlView),
    .prevIdle      (prevIdle),
    .latchOut      (latchOut),
    .addrValid     (addrValid),
    .endXferN      (endXferN),
    .parErrN       (parErrN),
    .mAbortN       (mAbortN)
  );

  pcs_control #(
    .ABORT_SINGLE (ABORT_SINGLE),
    .ABORT_BURST  (ABORT_BURST)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .ctlView  (ctlView),
    .prevIdle (prevIdle),
    .strobe   (strobe)
  );

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
  import pcs_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             stateMode,
  input logic             parityCheckEn,
  input busT              busIn,
  input ctlViewT          ctlView,
  input logic [BUS_W-1:0] latchOut,
  input logic             addrValid,
  input logic             endXferN,
  input logic             parErrN,
  input logic             mAbortN
);

  // R1: state-mode output equals the bus sampled on the previous edge
  p_latch_copy_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && stateMode) |-> (latchOut == $past(busIn)));

  // R3: strobe only follows a sampled FRAME# low, and lasts one clock
  p_strobe_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> !$past(busIn.frameN));
  p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> !addrValid);

  // R4: end flag reflects a last-data-phase sample, one clock wide
  p_end_shape_r4: assert property (@(posedge clk) disable iff (!rstN)
    !endXferN |-> $past(ctlView.frameN && !ctlView.irdyN && (!ctlView.trdyN || !ctlView.stopN)));
  p_end_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    !endXferN |=> endXferN);

  // R6: parity flag gated by enable
  p_par_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    !parErrN |-> $past(parityCheckEn));

  // R9: no abort on a clock where DEVSEL# was sampled low
  p_abort_nodev_r9: assert property (@(posedge clk) disable iff (!rstN)
    !mAbortN |-> $past(ctlView.devselN));

  // R7: abort is a single-clock pulse
  p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    !mAbortN |=> mAbortN);

endmodule

bind pci_cycle_status pcs_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .stateMode     (stateMode),
  .parityCheckEn (parityCheckEn),
  .busIn         (busIn),
  .ctlView       (ctlView),
  .latchOut      (latchOut),
  .addrValid     (addrValid),
  .endXferN      (endXferN),
  .parErrN       (parErrN),
  .mAbortN       (mAbortN)
);

// File: tb/pci_cycle_status_tb.sv
module pci_cycle_status_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stateMode = 1'b1;
  logic        parityCheckEn = 1'b1;
  logic [31:0] adIn = '0;
  logic [3:0]  cbeNIn = 4'hF;
  logic        parIn = 1'b0;
  logic        frameNIn = 1'b1, irdyNIn = 1'b1, trdyNIn = 1'b1, stopNIn = 1'b1, devselNIn = 1'b1;
  logic        idselIn = 1'b0, perrNIn = 1'b1, serrNIn = 1'b1;
  logic [44:0] latchOut;
  logic        addrValid, endXferN, parErrN, mAbortN;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] prevA = '0;
  logic [3:0]  prevC = 4'hF;

  always #(CLK_P/2) clk = ~clk;

  pci_cycle_status u_dut (
    .clk(clk), .rstN(rstN), .stateMode(stateMode), .parityCheckEn(parityCheckEn),
    .adIn(adIn), .cbeNIn(cbeNIn), .parIn(parIn), .frameNIn(frameNIn),
    .irdyNIn(irdyNIn), .trdyNIn(trdyNIn), .stopNIn(stopNIn), .devselNIn(devselNIn),
    .idselIn(idselIn), .perrNIn(perrNIn), .serrNIn(serrNIn),
    .latchOut(latchOut), .addrValid(addrValid), .endXferN(endXferN),
    .parErrN(parErrN), .mAbortN(mAbortN)
  );

  function automatic logic evenPar(input logic [31:0] a, input logic [3:0] c);
    return ^{a, c};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bus clock: drive at negedge, PAR carries parity of the previous
  // step's AD/CBE (optionally flipped); return 1 ns after the edge.
  task automatic step(input logic fr, input logic ir, input logic tr, input logic st,
                      input logic dv, input logic [31:0] a, input logic [3:0] c,
                      input logic flip);
    @(negedge clk);
    frameNIn = fr; irdyNIn = ir; trdyNIn = tr; stopNIn = st; devselNIn = dv;
    adIn = a; cbeNIn = c; parIn = evenPar(prevA, prevC) ^ flip;
    prevA = a; prevC = c;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic flip);
    step(1, 1, 1, 1, 1, 32'h0, 4'hF, flip);
  endtask

  task automatic t_reset();
    rstN = 0;
    step(0, 0, 0, 1, 0, 32'hDEAD_BEEF, 4'h0, 1);
    step(0, 0, 0, 1, 0, 32'hDEAD_BEEF, 4'h0, 1);
    chk("R10 reset endXferN", 64'(endXferN), 64'd1);
    chk("R10 reset parErrN",  64'(parErrN),  64'd1);
    chk("R10 reset mAbortN",  64'(mAbortN),  64'd1);
    chk("R10 reset addrValid", 64'(addrValid), 64'd0);
    idle(0);
    rstN = 1;
    idle(0); idle(0);
  endtask

  task automatic t_single_read();
    logic [31:0] a = 32'h1234_5678;
    logic [31:0] d = 32'hA5A5_0F0F;
    logic        p;
    p = evenPar(prevA, prevC);
    step(0, 1, 1, 1, 1, a, 4'h6, 0);
    chk("R3 strobe at address", 64'(addrValid), 64'd1);
    chk("R1 latched copy", 64'(latchOut),
        64'({a, 4'h6, p, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}));
    step(1, 0, 1, 1, 0, 32'h0, 4'h0, 0);
    chk("R3 strobe one clock", 64'(addrValid), 64'd0);
    step(1, 0, 0, 1, 0, d, 4'h3, 0);
    chk("R4 no end before last phase", 64'(endXferN), 64'd1);
    chk("R5 good address parity", 64'(parErrN), 64'd1);
    idle(0);
    chk("R4 end after last phase", 64'(endXferN), 64'd0);
    idle(0);
    chk("R4 end one clock", 64'(endXferN), 64'd1);
    chk("R5 good data parity", 64'(parErrN), 64'd1);
    idle(0);
  endtask

  task automatic t_burst_stop();
    step(0, 1, 1, 1, 1, 32'h0000_1000, 4'h7, 0);
    step(0, 0, 1, 1, 0, 32'h1111_1111, 4'h0, 0);
    chk("R3 no strobe while FRAME# held", 64'(addrValid), 64'd0);
    step(0, 0, 0, 1, 0, 32'h2222_2222, 4'h0, 0);
    step(1, 0, 1, 0, 0, 32'h3333_3333, 4'h0, 0);
    chk("R4 no end on middle beat", 64'(endXferN), 64'd1);
    idle(0);
    chk("R4 end on STOP# termination", 64'(endXferN), 64'd0);
    chk("R5 burst parity clean", 64'(parErrN), 64'd1);
    idle(0);
    chk("R4 STOP# end one clock", 64'(endXferN), 64'd1);
    idle(0);
  endtask

  task automatic t_parity_err();
    step(0, 1, 1, 1, 1, 32'h0F00_0001, 4'h7, 0);
    step(1, 0, 0, 1, 0, 32'hCAFE_0001, 4'h0, 1);
    chk("R5 no flag yet", 64'(parErrN), 64'd1);
    idle(1);
    chk("R5 address parity error", 64'(parErrN), 64'd0);
    idle(0);
    chk("R5 data parity error", 64'(parErrN), 64'd0);
    idle(0);
    chk("R5 flag clears", 64'(parErrN), 64'd1);
  endtask

  task automatic t_parity_wait();
    step(0, 1, 1, 1, 1, 32'h0000_2000, 4'h6, 0);
    step(0, 0, 1, 1, 0, 32'h7777_0000, 4'h0, 0);
    step(1, 0, 0, 1, 0, 32'h8888_0001, 4'h0, 1);
    idle(1);
    chk("R5 wait state not checked", 64'(parErrN), 64'd1);
    idle(0);
    chk("R5 data after wait checked", 64'(parErrN), 64'd0);
    idle(0);
  endtask

  task automatic t_parity_off();
    parityCheckEn = 0;
    step(0, 1, 1, 1, 1, 32'h0F00_0003, 4'h7, 0);
    step(1, 0, 0, 1, 0, 32'hCAFE_0003, 4'h0, 1);
    idle(1);
    chk("R6 disabled address", 64'(parErrN), 64'd1);
    idle(0);
    chk("R6 disabled data", 64'(parErrN), 64'd1);
    idle(0);
    parityCheckEn = 1;
  endtask

  task automatic t_abort_single();
    step(0, 1, 1, 1, 1, 32'h0000_3000, 4'h6, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 1, 1, 1, 32'h0, 4'h0, 0);
    chk("R7 no abort before timeout", 64'(mAbortN), 64'd1);
    idle(0);
    chk("R7 single abort at clock five", 64'(mAbortN), 64'd0);
    chk("R7 no end on abort", 64'(endXferN), 64'd1);
    idle(0);
    chk("R7 abort one clock", 64'(mAbortN), 64'd1);
    idle(0);
  endtask

  task automatic t_abort_burst();
    step(0, 1, 1, 1, 1, 32'h0000_4000, 4'h7, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 32'h0, 4'h0, 0);
    step(1, 0, 1, 1, 1, 32'h0, 4'h0, 0);
    chk("R8 no abort at clock five", 64'(mAbortN), 64'd1);
    idle(0);
    chk("R8 burst abort at clock six", 64'(mAbortN), 64'd0);
    idle(0);
    chk("R8 abort one clock", 64'(mAbortN), 64'd1);
    idle(0);
  endtask

  task automatic t_late_devsel();
    step(0, 1, 1, 1, 1, 32'h0000_5000, 4'h7, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1, 1, 32'h0, 4'h0, 0);
    step(0, 0, 1, 1, 0, 32'h0, 4'h0, 0);
    step(1, 0, 0, 1, 0, 32'h4444_0000, 4'h0, 0);
    chk("R9 DEVSEL# on clock six suppresses", 64'(mAbortN), 64'd1);
    idle(0);
    chk("R9 transfer completes", 64'(endXferN), 64'd0);
    chk("R9 still no abort", 64'(mAbortN), 64'd1);
    idle(0);
  endtask

  task automatic t_timing_mode();
    stateMode = 0;
    step(0, 1, 1, 1, 1, 32'hFFFF_FFFF, 4'h0, 0);
    chk("R2 timing mode released", 64'(latchOut !== {32'hFFFF_FFFF, 4'h0, evenPar(32'h0, 4'hF),
        1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}), 64'd1);
    chk("R3 strobe in timing mode", 64'(addrValid), 64'd1);
    idle(0);
    stateMode = 1;
    idle(0); idle(0);
  endtask

  task automatic t_reset_mid();
    step(0, 1, 1, 1, 1, 32'h0000_6000, 4'h7, 0);
    step(0, 0, 1, 1, 1, 32'h0, 4'h0, 0);
    step(0, 0, 1, 1, 1, 32'h0, 4'h0, 0);
    rstN = 0;
    step(1, 0, 1, 1, 1, 32'h0, 4'h0, 0);
    chk("R10 mid reset flags", 64'({endXferN, parErrN, mAbortN, addrValid}), 64'b1110);
    rstN = 1;
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 1, 1, 1, 32'h0, 4'h0, 0);
      chk("R10 tracking cleared", 64'(mAbortN), 64'd1);
    end
    idle(0); idle(0);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single_read();
    t_burst_stop();
    t_parity_err();
    t_parity_wait();
    t_parity_off();
    t_abort_single();
    t_abort_burst();
    t_late_devsel();
    t_timing_mode();
    t_reset_mid();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule